// File: doc/BRIEF.md
# Gateless JK Divide-by-Three

This block divides its clock by three using two JK flip-flops whose J and K pins are wired only to flip-flop outputs or to a constant. No combinational gate sits between the flip-flops. Each flip-flop follows the JK next-state rule Q+ = J·Q' + K'·Q. Flip-flop A is fed J = B' and K = B. Flip-flop B is fed J = A and K = 1.

The wiring walks the state (B,A) through 00, 01, 11 and then back to 00. Output A is therefore high for two cycles out of every three, and output B is high for one cycle out of three. Both flip-flops also drive complemented outputs.

A synchronous reset loads each flip-flop with its reset parameter, which is 0 by default. A clock enable freezes the state while it is low. The arrangement cannot make a 50% duty output.

Top module: `div3_jk`

## Requirements
- R1: While `srst` is high at a rising clock edge, A and B take the values of parameters `RST_A` and `RST_B` (default 0,0), whatever `en` is.
- R2: With `srst` low and `en` high, each rising edge moves the state (B,A) from 00 to 01, from 01 to 11, and from 11 to 00.
- R3: With `srst` low and `en` low, both A and B keep their values across the edge.
- R4: In steady enabled running the output period is three clock cycles. A is high for 2 of every 3 cycles and B is high for 1 of every 3 cycles, and B is never high on two enabled cycles in a row.
- R5: The unused state (B,A) = 10 goes to 00 on the first enabled edge.
- R6: `a_n_out` is always the inverse of `a_out`, and `b_n_out` is always the inverse of `b_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable, active high |
| a_out | output | 1 | Flip-flop A true output, 2/3 duty |
| a_n_out | output | 1 | Flip-flop A complemented output |
| b_out | output | 1 | Flip-flop B true output, 1/3 duty |
| b_n_out | output | 1 | Flip-flop B complemented output |

## Verification
The bench builds two copies of the block.

- **Default copy.** It is built with both reset parameters at 0. It carries the vector table, which covers reset, enable gating and the three-state walk. It also carries a long enabled run that measures the period and the high-time counts of A and B.
- **Second copy.** It is built with `RST_B = 1` and `RST_A = 0`, so reset parks it in the unused state 10. This is the only way to reach that state at the ports. It shows that a low enable keeps the copy there, and that one enabled edge brings it back to 00, after which it joins the normal sequence.

// File: rtl/div3_pkg.sv
package div3_pkg;

    // Register state of the divider: bit 1 is flip-flop B, bit 0 is flip-flop A.
    typedef struct packed {
        logic b;
        logic a;
    } div3_state_t;

    // Input pins of one JK element.
    typedef struct packed {
        logic j;
        logic k;
    } jk_pins_t;

    // JK characteristic equation: set on J when low, hold unless K when high.
    function automatic logic jk_next(input logic q, input jk_pins_t p);
        return (p.j & ~q) | (~p.k & q);
    endfunction

endpackage

// File: rtl/jk_cell.sv
module jk_cell
    import div3_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic     clk,
    input  logic     srst,
    input  logic     en,
    input  jk_pins_t pins,
    output logic     q
);

    logic q_d;
    logic q_q;

    // Next value: reset value, held value, or the JK rule.
    always_comb begin
        q_d = q_q;
        if (srst) begin
            q_d = RST_VAL;
        end else if (en) begin
            q_d = jk_next(q_q, pins);
        end
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    assign q = q_q;

    // J and K both high flips the element on an enabled edge.
    p_jk_toggle_r2: assert property (@(posedge clk) disable iff (srst)
        (en && pins.j && pins.k) |=> (q_q != $past(q_q)))
        else $error("p_jk_toggle_r2");

    // Enable low: the element keeps its value.
    p_jk_hold_r3: assert property (@(posedge clk) disable iff (srst)
        !en |=> $stable(q_q))
        else $error("p_jk_hold_r3");

endmodule

// File: rtl/div3_jk.sv
module div3_jk
    import div3_pkg::*;
#(
    parameter logic RST_A = 1'b0,
    parameter logic RST_B = 1'b0
) (
    input  logic clk,
    input  logic srst,
    input  logic en,
    output logic a_out,
    output logic a_n_out,
    output logic b_out,
    output logic b_n_out
);

    localparam int NUM_FF = 2;
    localparam logic [NUM_FF-1:0] RST_VEC = {RST_B, RST_A};

    div3_state_t        st_q;
    logic [NUM_FF-1:0]  q_w;
    jk_pins_t           pins_d [NUM_FF];

    // Feedback wiring only: every pin is a flip-flop output or a constant.
    always_comb begin
        pins_d[0].j = ~st_q.b;   // A: set while B is low
        pins_d[0].k =  st_q.b;   // A: clear once B is high
        pins_d[1].j =  st_q.a;   // B: set after A is high
        pins_d[1].k =  1'b1;     // B: never stays high
    end

    for (genvar gi = 0; gi < NUM_FF; gi++) begin : g_ff
        jk_cell #(
            .RST_VAL(RST_VEC[gi])
        ) u_ff (
            .clk  (clk),
            .srst (srst),
            .en   (en),
            .pins (pins_d[gi]),
            .q    (q_w[gi])
        );
    end

    assign st_q    = div3_state_t'(q_w);
    assign a_out   =  st_q.a;
    assign a_n_out = ~st_q.a;
    assign b_out   =  st_q.b;
    assign b_n_out = ~st_q.b;

    // Legal sequence 00 -> 01 -> 11 -> 00 on enabled edges.
    p_step_00_r2: assert property (@(posedge clk) disable iff (srst)
        (en && st_q == 2'b00) |=> (st_q == 2'b01))
        else $error("p_step_00_r2");

    p_step_01_r2: assert property (@(posedge clk) disable iff (srst)
        (en && st_q == 2'b01) |=> (st_q == 2'b11))
        else $error("p_step_01_r2");

    p_step_11_r2: assert property (@(posedge clk) disable iff (srst)
        (en && st_q == 2'b11) |=> (st_q == 2'b00))
        else $error("p_step_11_r2");

    // Enable low: both flip-flops keep their values.
    p_hold_r3: assert property (@(posedge clk) disable iff (srst)
        !en |=> $stable(st_q))
        else $error("p_hold_r3");

    // B is a single-cycle pulse.
    p_b_pulse_r4: assert property (@(posedge clk) disable iff (srst)
        (en && st_q.b) |=> !st_q.b)
        else $error("p_b_pulse_r4");

    // The unused state leaves to 00 in one enabled edge.
    p_escape_r5: assert property (@(posedge clk) disable iff (srst)
        (en && st_q == 2'b10) |=> (st_q == 2'b00))
        else $error("p_escape_r5");

endmodule

// File: tb/tb_div3_jk.sv
module tb_div3_jk;

    logic clk = 1'b0;
    logic srst = 1'b1;
    logic en = 1'b0;

    logic a, a_n, b, b_n;
    logic xa, xa_n, xb, xb_n;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    div3_jk dut (
        .clk(clk), .srst(srst), .en(en),
        .a_out(a), .a_n_out(a_n), .b_out(b), .b_n_out(b_n)
    );

    // Second copy parked by reset in the unused state (B,A)=10.
    div3_jk #(.RST_A(1'b0), .RST_B(1'b1)) dut_alt (
        .clk(clk), .srst(srst), .en(en),
        .a_out(xa), .a_n_out(xa_n), .b_out(xb), .b_n_out(xb_n)
    );

    // {srst, en, expected B, expected A}, as seen after the edge.
    localparam int NV = 14;
    localparam logic [3:0] VEC [NV] = '{
        4'b1100,  // R1 reset
        4'b0101,  // R2 00->01
        4'b0111,  // R2 01->11
        4'b0100,  // R2 11->00
        4'b0000,  // R3 hold 00
        4'b0101,  // R2
        4'b0001,  // R3 hold 01
        4'b0001,  // R3 hold 01
        4'b0111,  // R2
        4'b0100,  // R2
        4'b0101,  // R2
        4'b1100,  // R1 reset mid-count
        4'b1000,  // R1 reset with en low
        4'b0101   // R2 restart
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic e);
        @(negedge clk);
        srst = r;
        en = e;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int a_hi;
        int b_hi;
        int a_rise;
        int gap;
        int last_rise;
        logic a_prev;

        // Table walk: R1, R2, R3, with R6 on every step.
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][3], VEC[i][2]);
            check($sformatf("R1/R2/R3 vec %0d", i), {b, a}, VEC[i][1:0]);
            check("R6 complements", {b_n, a_n}, {~b, ~a});
        end

        // Long run: period and duty, R4.
        step(1'b1, 1'b1);
        check("R1 reset before run", {b, a}, 2'b00);
        a_hi = 0;
        b_hi = 0;
        a_rise = 0;
        gap = 0;
        last_rise = -1;
        a_prev = a;
        for (int c = 0; c < 90; c++) begin
            step(1'b0, 1'b1);
            if (a) a_hi++;
            if (b) b_hi++;
            if (a && !a_prev) begin
                if (last_rise >= 0 && (c - last_rise) != 3) gap++;
                last_rise = c;
                a_rise++;
            end
            a_prev = a;
            check("R6 complements run", {b_n, a_n}, {~b, ~a});
        end
        check("R4 A high cycles", 2'(a_hi == 60), 2'd1);
        check("R4 B high cycles", 2'(b_hi == 30), 2'd1);
        check("R4 A rising edges", 2'(a_rise == 30), 2'd1);
        check("R4 period of three", 2'(gap == 0), 2'd1);

        // Unused state recovery on dut_alt: R1, R3, R5.
        step(1'b1, 1'b0);
        check("R1 alt reset value", {xb, xa}, 2'b10);
        step(1'b0, 1'b0);
        check("R3 alt hold in 10", {xb, xa}, 2'b10);
        check("R6 alt complements", {xb_n, xa_n}, 2'b01);
        step(1'b0, 1'b1);
        check("R5 10 -> 00", {xb, xa}, 2'b00);
        step(1'b0, 1'b1);
        check("R5 rejoin 01", {xb, xa}, 2'b01);
        step(1'b0, 1'b1);
        check("R5 rejoin 11", {xb, xa}, 2'b11);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule